// File: doc/BRIEF.md
# Serial Command Read Engine

This block sits behind a serial slave shifter and interprets the command bytes that the shifter assembles from the serial input. Three commands are recognised. A one-byte stop command clears the continuous data output flag. A two-byte register read streams bytes back from a 16-entry register file. A two-byte RAM read streams bytes back from a 128-byte RAM that is split into eight banks of sixteen bytes each. Each read starts at an address taken from the command. The read address then advances by one for every byte that the shifter takes.

The shifter delivers each received byte as a one-cycle `rx_valid` pulse. It takes output bytes through a valid/ready pair, one byte per handshake, and shifts each byte out with bit 7 first. The select line frames every transaction, and dropping it abandons any command in progress. Conversion data is outside this block, so continuous output mode is reduced to one flag: a pulse on `cont_start` sets it and the stop command clears it. A load port fills the register file and the RAM, standing in for the write path that other logic owns.

Top module: `cmd_read_engine`

## Requirements
- R1: After reset, `tx_valid` and `cont_mode` are both 0.
- R2: The byte 0x0F, received as an opcode while selected, clears `cont_mode` from the next cycle. A `cont_start` pulse sets `cont_mode` from the next cycle. When both occur in the same cycle, the clear wins.
- R3: A register read is the byte 0x1r followed by a count byte. Bits 7:4 of the first byte are 0001 and bits 3:0 give the start register r. Bits 3:0 of the count byte give n, and its bits 7:4 are ignored. The read returns n+1 bytes from registers r, r+1, and so on.
- R4: During a register read, the address after register 15 is register 0, and output carries on from there.
- R5: A RAM read is the byte 0b00100bbb followed by a count byte. Bits 6:0 of the count byte give n, and bit 7 is ignored. The read returns n+1 bytes starting at address bbb×16 and rising by one each time. It crosses bank boundaries freely and wraps from address 127 to address 0.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, the same byte stays on offer. Each cycle with both high takes one byte. After the last byte is taken, `tx_valid` is 0 in the next cycle.
- R7: Any first byte other than 0x0F, 0x10–0x1F or 0x20–0x27 is discarded, and the next byte is decoded as an opcode.
- R8: Bytes that arrive while a read is streaming are ignored. They change neither the output sequence nor `cont_mode`.
- R9: While `sel` is 0, `tx_valid` is 0 from the next cycle on, and received bytes are ignored. A command that is partly received or still streaming is abandoned, and the first byte after reselection is decoded as an opcode.
- R10: Each cycle with `ld_en` high writes `ld_data` into the RAM at `ld_addr` when `ld_ram` is 1. When `ld_ram` is 0, it writes into register `ld_addr[3:0]` instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Transaction select, active high |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Shifter takes the offered byte |
| tx_valid | output | 1 | Output byte on offer |
| tx_byte | output | 8 | Output byte, bit 7 shifted first |
| cont_start | input | 1 | Pulse that enters continuous output mode |
| cont_mode | output | 1 | Continuous output mode flag |
| ld_en | input | 1 | Storage load strobe |
| ld_ram | input | 1 | Load target: 1 RAM, 0 register file |
| ld_addr | input | 7 | Load address |
| ld_data | input | 8 | Load data |

## Verification
Two events that can land in the same cycle both act on the continuous flag: a `cont_start` pulse, and a stop opcode arriving from the shifter. The bench drives both on one edge and expects `cont_mode` low in the following cycle. A second collision comes from dropping `sel` while a byte is on offer with `tx_ready` high. There the abort must win: no further byte may be counted, and the next command must decode cleanly. A per-clock reference model judges both cases, together with a byte-by-byte comparison of each stream against the loaded patterns.

// File: rtl/cre_pkg.sv
package cre_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_REGS   = 16;
    localparam int RAM_DEPTH  = 128;
    localparam int BANK_DEPTH = 16;
    localparam int REG_AW     = $clog2(NUM_REGS);
    localparam int RAM_AW     = $clog2(RAM_DEPTH);
    localparam int BANK_SEL_W = RAM_AW - $clog2(BANK_DEPTH);

    localparam logic [7:0] OPC_STOP    = 8'h0F;
    localparam logic [3:0] OPC_RREG_HI = 4'b0001;
    localparam logic [4:0] OPC_RRAM_HI = 5'b00100;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [RAM_AW-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REG_CNT,
        ST_RAM_CNT,
        ST_STREAM
    } cre_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_STOP,
        OP_RREG,
        OP_RRAM
    } cre_op_e;

    typedef struct packed {
        cre_op_e op;
        addr_t   base;
    } cre_dec_t;

    typedef struct packed {
        logic  ram;
        addr_t addr;
        addr_t left;
    } cre_cursor_t;

    // Classify a first byte; the start address is already scaled.
    function automatic cre_dec_t decode_opcode(byte_t b);
        cre_dec_t d;
        d.op   = OP_NONE;
        d.base = '0;
        if (b == OPC_STOP) begin
            d.op = OP_STOP;
        end else if (b[7:4] == OPC_RREG_HI) begin
            d.op = OP_RREG;
            d.base[REG_AW-1:0] = b[REG_AW-1:0];
        end else if (b[7:3] == OPC_RRAM_HI) begin
            d.op = OP_RRAM;
            d.base[RAM_AW-1:RAM_AW-BANK_SEL_W] = b[BANK_SEL_W-1:0];
        end
        return d;
    endfunction

    // Length-minus-one field of the second byte.
    function automatic addr_t count_field(logic ram, byte_t b);
        addr_t c;
        c = '0;
        if (ram) c = b[RAM_AW-1:0];
        else     c[REG_AW-1:0] = b[REG_AW-1:0];
        return c;
    endfunction

    // Following address: 4-bit wrap for registers, 7-bit wrap for RAM.
    function automatic addr_t next_addr(cre_cursor_t c);
        addr_t n;
        n = c.addr + 1'b1;
        if (!c.ram) begin
            n = '0;
            n[REG_AW-1:0] = c.addr[REG_AW-1:0] + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/cre_decoder.sv
module cre_decoder
    import cre_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_i,
    input  logic  rx_valid_i,
    input  byte_t rx_byte_i,
    input  logic  tx_ready_i,
    output logic  offer_o,
    output logic  stop_hit_o,
    output logic  rd_ram_o,
    output addr_t rd_addr_o,
    output addr_t left_o
);

    cre_state_e  state_q, state_d;
    cre_cursor_t cur_q, cur_d;
    cre_dec_t    dec;

    always_comb begin
        dec        = decode_opcode(rx_byte_i);
        state_d    = state_q;
        cur_d      = cur_q;
        stop_hit_o = 1'b0;
        if (!sel_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (rx_valid_i) begin
                        case (dec.op)
                            OP_STOP: stop_hit_o = 1'b1;
                            OP_RREG: begin
                                cur_d.ram  = 1'b0;
                                cur_d.addr = dec.base;
                                state_d    = ST_REG_CNT;
                            end
                            OP_RRAM: begin
                                cur_d.ram  = 1'b1;
                                cur_d.addr = dec.base;
                                state_d    = ST_RAM_CNT;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_REG_CNT: begin
                    if (rx_valid_i) begin
                        cur_d.left = count_field(1'b0, rx_byte_i);
                        state_d    = ST_STREAM;
                    end
                end
                ST_RAM_CNT: begin
                    if (rx_valid_i) begin
                        cur_d.left = count_field(1'b1, rx_byte_i);
                        state_d    = ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (tx_ready_i) begin
                        if (cur_q.left == '0) begin
                            state_d = ST_IDLE;
                        end else begin
                            cur_d.left = cur_q.left - 1'b1;
                            cur_d.addr = next_addr(cur_q);
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    assign offer_o   = sel_i && (state_q == ST_STREAM);
    assign rd_ram_o  = cur_q.ram;
    assign rd_addr_o = cur_q.addr;
    assign left_o    = cur_q.left;

endmodule

// File: rtl/cre_regfile.sv
module cre_regfile #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(i))) val_q <= wr_data;
        end
        assign ent[i] = val_q;
    end

    assign rd_data = ent[rd_addr];

endmodule

// File: rtl/cre_ram.sv
module cre_ram #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cmd_read_engine.sv
module cmd_read_engine
    import cre_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              cont_start,
    output logic              cont_mode,
    input  logic              ld_en,
    input  logic              ld_ram,
    input  logic [RAM_AW-1:0] ld_addr,
    input  logic [BYTE_W-1:0] ld_data
);

    logic  offer;
    logic  stop_hit;
    logic  rd_ram;
    addr_t rd_addr;
    addr_t left;
    byte_t reg_rd;
    byte_t ram_rd;
    logic  cont_q;

    cre_decoder u_dec (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (sel),
        .rx_valid_i (rx_valid),
        .rx_byte_i  (rx_byte),
        .tx_ready_i (tx_ready),
        .offer_o    (offer),
        .stop_hit_o (stop_hit),
        .rd_ram_o   (rd_ram),
        .rd_addr_o  (rd_addr),
        .left_o     (left)
    );

    cre_regfile #(.DEPTH(NUM_REGS), .W(BYTE_W)) u_regs (
        .clk     (clk),
        .wr_en   (ld_en && !ld_ram),
        .wr_addr (ld_addr[REG_AW-1:0]),
        .wr_data (ld_data),
        .rd_addr (rd_addr[REG_AW-1:0]),
        .rd_data (reg_rd)
    );

    cre_ram #(.DEPTH(RAM_DEPTH), .W(BYTE_W)) u_ram (
        .clk     (clk),
        .wr_en   (ld_en && ld_ram),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (rd_addr),
        .rd_data (ram_rd)
    );

    // Clear from the stop opcode takes priority over a same-cycle set.
    always_ff @(posedge clk) begin
        if (rst)             cont_q <= 1'b0;
        else if (stop_hit)   cont_q <= 1'b0;
        else if (cont_start) cont_q <= 1'b1;
    end

    assign tx_valid  = offer;
    assign tx_byte   = rd_ram ? ram_rd : reg_rd;
    assign cont_mode = cont_q;

endmodule

// File: rtl/cre_checker.sv
module cre_checker
    import cre_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  sel,
    input logic  tx_valid,
    input logic  tx_ready,
    input logic  cont_start,
    input logic  cont_mode,
    input logic  stop_hit,
    input logic  rd_ram,
    input addr_t rd_addr,
    input addr_t left
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!tx_valid && !cont_mode)); // R1

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stop_hit |=> !cont_mode); // R2

    AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
        (cont_start && !stop_hit) |=> cont_mode); // R2

    AST_REG_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !rd_ram && (rd_addr == addr_t'(NUM_REGS - 1)) && (left != '0))
        |=> (rd_addr == '0)); // R4

    AST_RAM_STEP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && rd_ram && (left != '0))
        |=> (rd_addr == addr_t'($past(rd_addr) + 1'b1))); // R5

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && sel) |=> tx_valid); // R6

    AST_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && (left == '0)) |=> !tx_valid); // R6

    AST_STREAM_DEAF: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && sel) |=> ($stable(rd_addr) && $stable(left))); // R8

    AST_DESELECT_ABORT: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !tx_valid); // R9

endmodule

bind cmd_read_engine cre_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .cont_start (cont_start),
    .cont_mode  (cont_mode),
    .stop_hit   (stop_hit),
    .rd_ram     (rd_ram),
    .rd_addr    (rd_addr),
    .left       (left)
);

// File: tb/cmd_read_engine_tb.sv
module cmd_read_engine_tb;

    logic       clk = 1'b0;
    logic       rst, sel, rx_valid, tx_ready, cont_start, ld_en, ld_ram;
    logic [7:0] rx_byte, ld_data, tx_byte;
    logic [6:0] ld_addr;
    logic       tx_valid, cont_mode;

    always #10 clk = ~clk;

    cmd_read_engine u_dut (
        .clk(clk), .rst(rst), .sel(sel), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .cont_start(cont_start), .cont_mode(cont_mode),
        .ld_en(ld_en), .ld_ram(ld_ram), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    int         checks = 0;
    int         fails  = 0;
    bit         run    = 0;
    string      phase  = "R1";
    logic [3:0] ready_pat = 4'hF;
    int         cyc = 0;
    logic [7:0] got[$];
    logic [7:0] expq[$];

    // behavioural reference: 0 idle, 1 reg count, 2 ram count, 3 stream
    int         m_state = 0, m_addr = 0, m_left = 0;
    bit         m_ram = 0, m_cont = 0;
    logic [7:0] reg_m [16];
    logic [7:0] ram_m [128];

    function automatic logic [7:0] reg_pat(int i);
        return 8'(8'h80 + i * 5);
    endfunction

    function automatic logic [7:0] ram_pat(int a);
        return 8'(a * 3 + 8'h11);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (ld_en) begin
            if (ld_ram) ram_m[ld_addr] = ld_data;
            else        reg_m[ld_addr[3:0]] = ld_data;
        end
        if (rst) begin
            m_state = 0;
            m_cont  = 0;
        end else begin
            if (sel && m_state == 0 && rx_valid && rx_byte == 8'h0F) m_cont = 0;
            else if (cont_start) m_cont = 1;
            if (!sel) m_state = 0;
            else begin
                case (m_state)
                    0: if (rx_valid) begin
                        if (rx_byte[7:4] == 4'h1) begin
                            m_ram = 0; m_addr = int'(rx_byte[3:0]); m_state = 1;
                        end else if (rx_byte[7:3] == 5'b00100) begin
                            m_ram = 1; m_addr = int'(rx_byte[2:0]) * 16; m_state = 2;
                        end
                    end
                    1: if (rx_valid) begin m_left = int'(rx_byte[3:0]); m_state = 3; end
                    2: if (rx_valid) begin m_left = int'(rx_byte[6:0]); m_state = 3; end
                    default: if (tx_ready) begin
                        if (m_left == 0) m_state = 0;
                        else begin
                            m_left = m_left - 1;
                            m_addr = m_ram ? (m_addr + 1) % 128 : (m_addr + 1) % 16;
                        end
                    end
                endcase
            end
        end
    end

    always @(posedge clk) begin
        #2;
        cyc++;
        tx_ready = ready_pat[cyc % 4];
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (run && !rst) begin
            chk(phase, int'(tx_valid), int'(m_state == 3 && sel));
            if (m_state == 3 && sel)
                chk(phase, int'(tx_byte), int'(m_ram ? ram_m[m_addr] : reg_m[m_addr]));
            chk(phase, int'(cont_mode), int'(m_cont));
            if (tx_valid && tx_ready && sel) got.push_back(tx_byte);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [7:0] b, input bit with_start = 0);
        tick();
        rx_valid   = 1'b1;
        rx_byte    = b;
        cont_start = with_start;
        tick();
        rx_valid   = 1'b0;
        cont_start = 1'b0;
    endtask

    task automatic wait_idle();
        do tick(); while (m_state != 0);
    endtask

    task automatic check_got(string req);
        chk(req, got.size(), expq.size());
        foreach (expq[i]) if (i < got.size()) chk(req, int'(got[i]), int'(expq[i]));
        got.delete();
        expq.delete();
    endtask

    task automatic read_reg(string req, int s, int n, logic [3:0] hi = 4'h0);
        phase = req;
        got.delete();
        send({4'h1, 4'(s)});
        send({hi, 4'(n)});
        wait_idle();
        for (int i = 0; i <= n; i++) expq.push_back(reg_pat((s + i) % 16));
        check_got(req);
    endtask

    task automatic read_ram(string req, int bank, int n, bit hi = 0);
        phase = req;
        got.delete();
        send({5'b00100, 3'(bank)});
        send({hi, 7'(n)});
        wait_idle();
        for (int i = 0; i <= n; i++) expq.push_back(ram_pat((bank * 16 + i) % 128));
        check_got(req);
    endtask

    task automatic pulse_start();
        tick();
        cont_start = 1'b1;
        tick();
        cont_start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (%s): actual running expected finished", phase);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; sel = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; tx_ready = 1'b1;
        cont_start = 1'b0; ld_en = 1'b0; ld_ram = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(tx_valid), 0);
        chk("R1", int'(cont_mode), 0);
        run = 1;
        sel = 1'b1;

        phase = "R10";
        for (int i = 0; i < 16; i++) begin
            tick(); ld_en = 1'b1; ld_ram = 1'b0; ld_addr = 7'(i); ld_data = reg_pat(i);
        end
        for (int a = 0; a < 128; a++) begin
            tick(); ld_en = 1'b1; ld_ram = 1'b1; ld_addr = 7'(a); ld_data = ram_pat(a);
        end
        tick(); ld_en = 1'b0;

        phase = "R2";
        pulse_start();
        @(negedge clk); chk("R2 set", int'(cont_mode), 1);
        send(8'h0F);
        @(negedge clk); chk("R2 clear", int'(cont_mode), 0);
        pulse_start();
        send(8'h0F, 1'b1);
        @(negedge clk); chk("R2 collision", int'(cont_mode), 0);
        pulse_start();

        read_reg("R3", 2, 3, 4'hF);
        read_reg("R4", 15, 2);
        read_reg("R3 R10", 0, 15);
        read_reg("R4", 9, 15);
        ready_pat = 4'b0101;
        read_reg("R6", 6, 4);
        ready_pat = 4'hF;
        read_ram("R5", 1, 20, 1'b1);
        read_ram("R5", 7, 20);
        read_ram("R5 R10", 0, 127);

        phase = "R7";
        got.delete();
        send(8'h0E);
        send(8'h2B);
        send(8'h13);
        send(8'h01);
        wait_idle();
        expq.push_back(reg_pat(3));
        expq.push_back(reg_pat(4));
        check_got("R7");

        phase = "R8";
        ready_pat = 4'b0001;
        got.delete();
        send(8'h10);
        send(8'h05);
        send(8'h0F);
        send(8'h21);
        send(8'h13);
        wait_idle();
        for (int i = 0; i <= 5; i++) expq.push_back(reg_pat(i));
        check_got("R8");
        chk("R8", int'(cont_mode), 1);
        ready_pat = 4'hF;

        phase = "R9";
        send(8'h12);
        tick(); sel = 1'b0;
        send(8'h0F);
        tick(); sel = 1'b1;
        got.delete();
        send(8'h10);
        send(8'h00);
        wait_idle();
        expq.push_back(reg_pat(0));
        check_got("R9");
        chk("R9", int'(cont_mode), 1);
        send(8'h10);
        send(8'h0F);
        tick(); tick();
        sel = 1'b0;
        @(negedge clk); chk("R9 abort", int'(tx_valid), 0);
        tick();
        @(negedge clk); chk("R9 abort", int'(tx_valid), 0);
        sel = 1'b1;
        read_reg("R9", 4, 1);

        run = 0;
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule